// File: doc/BRIEF.md
# Dual-Rule Vector Order Comparator

This block compares two unsigned bit vectors whose widths may differ and reports whether the first is below, above or equal to the second. A single select input chooses the ordering rule. Under the string rule each vector is read as a sequence of bit elements starting from its most significant end. The first position where the two sequences disagree settles the order. When one sequence runs out before any disagreement, it is the lesser. Under the value rule both vectors are unsigned binary numbers, and the narrower one is padded with zeros on the left before the magnitudes are compared.

The block is purely combinational, with no clock and no reset. Its outputs follow the inputs within the same evaluation. Each operand width is a parameter from 1 to 32, and the two widths may be equal. Exactly one of the three result flags is high at any time.

Top module: `vec_order_cmp`

## Requirements
- R1: With mode_i = 0 (string rule), bit a_i[WA-1-k] is paired with z_i[WZ-1-k] for k counting up from 0. The first pair that disagrees decides the order: the operand holding 1 at that pair is the greater.
- R2: With mode_i = 0, if all min(WA, WZ) pairs agree, the narrower operand is the lesser. eq_o is set only when WA equals WZ.
- R3: With mode_i = 1 (value rule), the result is the unsigned comparison of a_i and z_i after the narrower one is zero-extended. The widths themselves play no part.
- R4: Exactly one of lt_o, gt_o and eq_o is 1 for every input combination.
- R5: With WA different from WZ and mode_i = 0, eq_o is never 1, even when the shared leading bits are identical.
- R6: With WA = 8 and WZ = 4, a_i = 00000000 and z_i = 1111 under the string rule give lt_o = 1 and gt_o = 0.
- R7: With WA = 8 and WZ = 4, a_i = 10111111 and z_i = 1111 give lt_o = 1 under the string rule and gt_o = 1 under the value rule. a_i = 00011111 behaves the same way, because 31 exceeds 15 by value.
- R8: With WA = 8 and WZ = 4, any a_i whose upper four bits are 1111, compared with z_i = 1111, gives gt_o = 1 and lt_o = 0 under both rules.
- R9: Changing only mode_i switches the rule applied to unchanged operands, with the outputs updated in the same evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WA | First operand |
| z_i | input | WZ | Second operand |
| mode_i | input | 1 | Ordering rule: 0 string, 1 value |
| lt_o | output | 1 | a_i orders before z_i |
| gt_o | output | 1 | a_i orders after z_i |
| eq_o | output | 1 | Operands are equal under the chosen rule |

## Verification
The main instance is built with WA = 8 and WZ = 4, which gives the fixed-pattern cases and prefix ties where the wider operand wins on length. Further instances are built with (4, 8), (5, 5), (1, 7), (32, 3) and (16, 32). These bring into reach the case where the narrower operand is the left one, equal widths where the string rule can report equality, a one-bit operand where the whole comparison rests on a single pair, and full 32-bit operands. Random operands on those instances are biased so that the shared leading bits often match, which exercises the length tie-break under the string rule.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [1:0] {
    ORD_EQ = 2'b00,
    ORD_LT = 2'b01,
    ORD_GT = 2'b10
  } ord_e;

  typedef enum logic {
    MODE_LEX = 1'b0,
    MODE_NUM = 1'b1
  } mode_e;
endpackage

// File: rtl/vcmp_mag.sv
// Equal-width unsigned magnitude order; the highest differing bit wins.
module vcmp_mag
  import vcmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output ord_e         ord_o
);
  always_comb begin
    ord_o = ORD_EQ;
    for (int i = 0; i < W; i++) begin
      if (x_i[i] != y_i[i]) ord_o = x_i[i] ? ORD_GT : ORD_LT;
    end
  end
endmodule

// File: rtl/vcmp_lex.sv
// String ordering: the leading parts are compared first, then length decides.
module vcmp_lex
  import vcmp_pkg::*;
#(
  parameter int WA = 8,
  parameter int WZ = 4,
  localparam int WMIN = (WA < WZ) ? WA : WZ
) (
  input  logic [WMIN-1:0] a_head_i,
  input  logic [WMIN-1:0] z_head_i,
  output ord_e            ord_o
);
  ord_e head_ord;
  ord_e tie_ord;

  vcmp_mag #(.W(WMIN)) i_head (
    .x_i  (a_head_i),
    .y_i  (z_head_i),
    .ord_o(head_ord)
  );

  generate
    if (WA < WZ) begin : g_a_short
      assign tie_ord = ORD_LT;
    end else if (WA > WZ) begin : g_a_long
      assign tie_ord = ORD_GT;
    end else begin : g_same
      assign tie_ord = ORD_EQ;
    end
  endgenerate

  assign ord_o = (head_ord == ORD_EQ) ? tie_ord : head_ord;
endmodule

// File: rtl/vcmp_num.sv
// Value ordering after zero-extension to the wider width.
module vcmp_num
  import vcmp_pkg::*;
#(
  parameter int WA = 8,
  parameter int WZ = 4,
  localparam int WMAX = (WA > WZ) ? WA : WZ
) (
  input  logic [WA-1:0] a_i,
  input  logic [WZ-1:0] z_i,
  output ord_e          ord_o
);
  logic [WMAX-1:0] a_ext;
  logic [WMAX-1:0] z_ext;

  assign a_ext = WMAX'(a_i);
  assign z_ext = WMAX'(z_i);

  vcmp_mag #(.W(WMAX)) i_mag (
    .x_i  (a_ext),
    .y_i  (z_ext),
    .ord_o(ord_o)
  );
endmodule

// File: rtl/vec_order_cmp.sv
module vec_order_cmp
  import vcmp_pkg::*;
#(
  parameter int WA = 8,
  parameter int WZ = 4
) (
  input  logic [WA-1:0] a_i,
  input  logic [WZ-1:0] z_i,
  input  logic          mode_i,
  output logic          lt_o,
  output logic          gt_o,
  output logic          eq_o
);
  localparam int WMIN = (WA < WZ) ? WA : WZ;

  ord_e lex_ord;
  ord_e num_ord;
  ord_e sel_ord;

  vcmp_lex #(.WA(WA), .WZ(WZ)) i_lex (
    .a_head_i(a_i[WA-1 -: WMIN]),
    .z_head_i(z_i[WZ-1 -: WMIN]),
    .ord_o   (lex_ord)
  );

  vcmp_num #(.WA(WA), .WZ(WZ)) i_num (
    .a_i  (a_i),
    .z_i  (z_i),
    .ord_o(num_ord)
  );

  assign sel_ord = (mode_e'(mode_i) == MODE_NUM) ? num_ord : lex_ord;

  assign lt_o = (sel_ord == ORD_LT);
  assign gt_o = (sel_ord == ORD_GT);
  assign eq_o = (sel_ord == ORD_EQ);
endmodule

// File: rtl/vcmp_check.sv
module vcmp_check #(
  parameter int WA = 8,
  parameter int WZ = 4
) (
  input logic [WA-1:0] a_i,
  input logic [WZ-1:0] z_i,
  input logic          mode_i,
  input logic          lt_o,
  input logic          gt_o,
  input logic          eq_o
);
  localparam int WMAX = (WA > WZ) ? WA : WZ;

  always_comb begin
    if (!$isunknown({a_i, z_i, mode_i, lt_o, gt_o, eq_o})) begin
      p_one_flag_r4: assert ($onehot({lt_o, gt_o, eq_o}));
      if (!mode_i && eq_o) begin
        p_lex_eq_width_r5: assert (WA == WZ);
      end
      if (!mode_i && (a_i[WA-1] != z_i[WZ-1])) begin
        p_lex_lead_r1: assert (lt_o == z_i[WZ-1] && gt_o == a_i[WA-1]);
      end
      if (mode_i && eq_o) begin
        p_num_eq_value_r3: assert (WMAX'(a_i) == WMAX'(z_i));
      end
      if (mode_i && (a_i == '0)) begin
        p_num_zero_r3: assert (!gt_o);
      end
    end
  end
endmodule

bind vec_order_cmp vcmp_check #(.WA(WA), .WZ(WZ)) i_check (.*);

// File: tb/test_vec_order_cmp.sv
module test_vec_order_cmp;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;
  localparam int PA [NP] = '{4, 5, 1, 32, 16, 8};
  localparam int PB [NP] = '{8, 5, 7, 3, 32, 8};
  localparam int N_RAND = 200;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [NP-1:0] pair_done = '0;

  // expected result encoded as {lt, gt, eq}
  function automatic logic [2:0] ref_cmp(input logic [31:0] a, input int wa,
                                         input logic [31:0] z, input int wz,
                                         input bit num);
    int wmin;
    if (num) begin
      if (a < z) return 3'b100;
      if (a > z) return 3'b010;
      return 3'b001;
    end
    wmin = (wa < wz) ? wa : wz;
    for (int k = 0; k < wmin; k++) begin
      if (a[wa-1-k] != z[wz-1-k]) return a[wa-1-k] ? 3'b010 : 3'b100;
    end
    if (wa < wz) return 3'b100;
    if (wa > wz) return 3'b010;
    return 3'b001;
  endfunction

  // main instance, scoreboard driven
  logic [7:0] a_s;
  logic [3:0] z_s;
  logic       mode_s;
  logic       lt_s, gt_s, eq_s;

  vec_order_cmp #(.WA(8), .WZ(4)) i_vec_order_cmp (
    .a_i   (a_s),
    .z_i   (z_s),
    .mode_i(mode_s),
    .lt_o  (lt_s),
    .gt_o  (gt_s),
    .eq_o  (eq_s)
  );

  typedef struct {
    logic [2:0] exp;
    string      tag;
    logic [7:0] a;
    logic [3:0] z;
    bit         m;
  } item_t;

  item_t sb_q[$];
  item_t it;

  task automatic drive(input logic [7:0] a, input logic [3:0] z, input bit m,
                       input logic [2:0] exp, input string tag);
    item_t e;
    @(posedge clk);
    a_s = a;
    z_s = z;
    mode_s = m;
    e.exp = exp;
    e.tag = tag;
    e.a = a;
    e.z = z;
    e.m = m;
    sb_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      n_tests++;
      if ({lt_s, gt_s, eq_s} !== it.exp) begin
        n_fail++;
        $display("FAIL %s a=%b z=%b mode=%0d actual lt/gt/eq=%b expected=%b",
                 it.tag, it.a, it.z, it.m, {lt_s, gt_s, eq_s}, it.exp);
      end
    end
  end

  // further width pairs, checked against the reference model
  for (genvar g = 0; g < NP; g++) begin : g_pair
    localparam int GA = PA[g];
    localparam int GZ = PB[g];
    localparam int GMIN = (GA < GZ) ? GA : GZ;
    logic [GA-1:0] ga;
    logic [GZ-1:0] gz;
    logic          gm;
    logic          glt, ggt, geq;

    vec_order_cmp #(.WA(GA), .WZ(GZ)) i_pair (
      .a_i   (ga),
      .z_i   (gz),
      .mode_i(gm),
      .lt_o  (glt),
      .gt_o  (ggt),
      .eq_o  (geq)
    );

    initial begin
      logic [2:0] exp;
      ga = '0;
      gz = '0;
      gm = 1'b0;
      wait (rst_ni);
      for (int n = 0; n < N_RAND; n++) begin
        @(posedge clk);
        ga = GA'($urandom);
        gz = GZ'($urandom);
        gm = 1'($urandom);
        if (n % 3 == 0) begin
          for (int k = 0; k < GMIN; k++) ga[GA-1-k] = gz[GZ-1-k];
        end
        @(negedge clk);
        exp = ref_cmp(32'(ga), GA, 32'(gz), GZ, gm);
        n_tests++;
        if ({glt, ggt, geq} !== exp) begin
          n_fail++;
          $display("FAIL %s pair %0dx%0d a=%h z=%h mode=%0d actual=%b expected=%b",
                   gm ? "R3" : "R1/R2/R5", GA, GZ, ga, gz, gm,
                   {glt, ggt, geq}, exp);
        end
        n_tests++;
        if ($countones({glt, ggt, geq}) != 1) begin
          n_fail++;
          $display("FAIL R4 pair %0dx%0d actual=%b expected one flag",
                   GA, GZ, {glt, ggt, geq});
        end
      end
      pair_done[g] = 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL R4 watchdog actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ra;
    logic [3:0] rz;
    bit rm;
    a_s = '0;
    z_s = '0;
    mode_s = 1'b1;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // first state after release: zero operands, value rule
    drive(8'h00, 4'h0, 1'b1, 3'b001, "R3 idle");
    drive(8'h00, 4'hF, 1'b0, 3'b100, "R6");
    drive(8'hBF, 4'hF, 1'b0, 3'b100, "R7 string");
    drive(8'hBF, 4'hF, 1'b1, 3'b010, "R7 value");
    drive(8'h1F, 4'hF, 1'b0, 3'b100, "R7 string 31");
    drive(8'h1F, 4'hF, 1'b1, 3'b010, "R7 value 31");
    for (int lo = 0; lo < 16; lo += 5) begin
      drive({4'hF, 4'(lo)}, 4'hF, 1'b0, 3'b010, "R8 string");
      drive({4'hF, 4'(lo)}, 4'hF, 1'b1, 3'b010, "R8 value");
    end
    // prefix tie: longer operand wins, never equal
    drive(8'h50, 4'h5, 1'b0, 3'b010, "R2/R5 tie");
    drive(8'h05, 4'h5, 1'b1, 3'b001, "R3 equal value");
    drive(8'h05, 4'h5, 1'b0, 3'b100, "R9 same operands string");
    drive(8'h80, 4'h7, 1'b0, 3'b010, "R1 lead");
    drive(8'h7F, 4'h8, 1'b0, 3'b100, "R1 lead");
    drive(8'h7F, 4'h8, 1'b1, 3'b010, "R9 same operands value");
    for (int n = 0; n < 300; n++) begin
      ra = 8'($urandom);
      rz = 4'($urandom);
      rm = 1'($urandom);
      if (n % 3 == 0) ra[7:4] = rz;
      drive(ra, rz, rm, ref_cmp(32'(ra), 8, 32'(rz), 4, rm),
            rm ? "R3 random" : "R1/R2 random");
    end
    @(negedge clk);
    wait (&pair_done);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule